// File: doc/BRIEF.md
# CSR Instruction Access Executor

This block carries out the three atomic control-register instructions of a processor core: swap (read-write), bit-set (read-set) and bit-clear (read-clear). Each request names a 12-bit register number, a source operand and a flag that tells whether the source register index was nonzero. The executor reads the old value from an external register bank and decides whether the access is allowed. It then returns the old value for the destination register and, when a write is due, drives a one-cycle write into the bank.

Legality comes from two sources. The first is the register number itself: bits 9:8 give the lowest privilege that may touch the register, and a value of 3 in bits 11:10 marks the register read-only. The second is a hit signal from the bank, which reports whether the number is implemented at all. A denied access raises a one-cycle illegal flag alongside the response strobe, returns zero and writes nothing. Bit-set and bit-clear with a zero source index are pure reads. For them the write and the read-only test are both skipped.

The bank read is combinational: the request address is passed straight to the bank, and the data and hit returned in the same cycle are used. All outputs are registered, so the response and the write appear one clock after the request.

Top module: `csr_access_unit`

## Requirements
- R1: A request with op code 01 (read-write), 10 (read-set) or 11 (read-clear) gives `rsp_valid` high for exactly the cycle after the request cycle. A request with op code 00 produces neither a response nor a write.
- R2: For a legal access, `rsp_rdata` equals the bank value presented on `bank_rdata` in the request cycle, which is the value before the access.
- R3: A legal read-write writes the source value to the requested address, whatever the source-index flag says.
- R4: A legal read-set with a nonzero source index writes old OR source. A legal read-clear with a nonzero source index writes old AND NOT source.
- R5: Read-set or read-clear with a zero source index never writes. It is not subject to the read-only test, so it may read a read-only register.
- R6: When `cur_priv` is numerically below address bits 9:8, the access is illegal.
- R7: When address bits 11:10 equal 3 and the access is a write (read-write, or set/clear with a nonzero source index), the access is illegal.
- R8: When `bank_hit` is low in the request cycle, the access is illegal.
- R9: An illegal access asserts `rsp_illegal` together with `rsp_valid` for one cycle. It returns zero on `rsp_rdata` and asserts no `wr_en`.
- R10: During and right after reset, `rsp_valid`, `rsp_illegal` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 01 swap, 10 set bits, 11 clear bits, 00 none |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register index is nonzero |
| req_addr | input | 12 | Register number |
| cur_priv | input | 2 | Current privilege level |
| bank_addr | output | 12 | Read address to the bank (combinational) |
| bank_rdata | input | XLEN | Bank read data for `bank_addr` |
| bank_hit | input | 1 | `bank_addr` names an implemented register |
| rsp_valid | output | 1 | Response strobe |
| rsp_illegal | output | 1 | Access raised illegal instruction |
| rsp_rdata | output | XLEN | Old register value, zero when illegal |
| wr_en | output | 1 | Bank write strobe |
| wr_addr | output | 12 | Bank write address |
| wr_data | output | XLEN | Bank write data |

## Verification
The riskiest cases are set and clear with a zero source index aimed at a read-only register. A design that applied the read-only test before looking at the index would flag these legal reads as illegal, and one that still pulsed the write would corrupt the bank. The bench also drives each privilege boundary exactly: level equal to the address level must pass and one below must fail, so an off-by-one comparison shows up as a wrong illegal flag. Unmapped addresses, op code 00 and the merge arithmetic for set and clear all run under random operands. A wrong merge therefore shows up as a write-data mismatch, and a write leaking from an illegal access shows up as a stray `wr_en`.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    localparam int CSR_AW = 12;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SETB = 2'b10,
        OP_CLRB = 2'b11
    } csr_op_e;

    // Address fields the legality check decodes
    localparam int PRIV_LO = 8;
    localparam int PRIV_HI = 9;
    localparam int ACC_LO  = 10;
    localparam int ACC_HI  = 11;
    localparam logic [1:0] ACC_RDONLY = 2'b11;

endpackage

// File: rtl/csr_acc_guard.sv
module csr_acc_guard
    import csr_exec_pkg::*;
(
    input  logic [1:0] op,
    input  logic       src_nz,
    input  logic [1:0] addr_acc,
    input  logic [1:0] addr_priv,
    input  logic [1:0] cur_priv,
    input  logic       hit,
    output logic       write_intent,
    output logic       illegal
);
    logic priv_fail;
    logic ro_fail;

    always_comb begin
        unique case (csr_op_e'(op))
            OP_SWAP:          write_intent = 1'b1;
            OP_SETB, OP_CLRB: write_intent = src_nz;
            default:          write_intent = 1'b0;
        endcase
        priv_fail = cur_priv < addr_priv;
        ro_fail   = write_intent && (addr_acc == ACC_RDONLY);
        illegal   = priv_fail || ro_fail || !hit;
    end
endmodule

// File: rtl/csr_acc_merge.sv
module csr_acc_merge
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        unique case (csr_op_e'(op))
            OP_SWAP: new_val = src;
            OP_SETB: new_val = old_val | src;
            OP_CLRB: new_val = old_val & ~src;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [XLEN-1:0]   req_src,
    input  logic              req_src_nz,
    input  logic [CSR_AW-1:0] req_addr,
    input  logic [1:0]        cur_priv,
    output logic [CSR_AW-1:0] bank_addr,
    input  logic [XLEN-1:0]   bank_rdata,
    input  logic              bank_hit,
    output logic              rsp_valid,
    output logic              rsp_illegal,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              wr_en,
    output logic [CSR_AW-1:0] wr_addr,
    output logic [XLEN-1:0]   wr_data
);
    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_illegal;
        logic [XLEN-1:0]   rsp_rdata;
        logic              wr_en;
        logic [CSR_AW-1:0] wr_addr;
        logic [XLEN-1:0]   wr_data;
    } state_t;

    state_t state_d, state_q;
    logic            write_intent;
    logic            illegal;
    logic [XLEN-1:0] merged;

    assign bank_addr = req_addr;

    csr_acc_guard i_guard (
        .op           (req_op),
        .src_nz       (req_src_nz),
        .addr_acc     (req_addr[ACC_HI:ACC_LO]),
        .addr_priv    (req_addr[PRIV_HI:PRIV_LO]),
        .cur_priv     (cur_priv),
        .hit          (bank_hit),
        .write_intent (write_intent),
        .illegal      (illegal)
    );

    csr_acc_merge #(.XLEN(XLEN)) i_merge (
        .op      (req_op),
        .src     (req_src),
        .old_val (bank_rdata),
        .new_val (merged)
    );

    always_comb begin
        logic active;
        active                = req_valid && (req_op != OP_NONE);
        state_d               = state_q;
        state_d.rsp_valid     = active;
        state_d.rsp_illegal   = active && illegal;
        state_d.wr_en         = active && !illegal && write_intent;
        state_d.rsp_rdata     = (active && !illegal) ? bank_rdata : '0;
        if (active) begin
            state_d.wr_addr = req_addr;
            state_d.wr_data = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid   = state_q.rsp_valid;
    assign rsp_illegal = state_q.rsp_illegal;
    assign rsp_rdata   = state_q.rsp_rdata;
    assign wr_en       = state_q.wr_en;
    assign wr_addr     = state_q.wr_addr;
    assign wr_data     = state_q.wr_data;
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              req_src_nz,
    input logic [CSR_AW-1:0] req_addr,
    input logic [1:0]        cur_priv,
    input logic              rsp_valid,
    input logic              rsp_illegal,
    input logic [XLEN-1:0]   rsp_rdata,
    input logic              wr_en,
    input logic [CSR_AW-1:0] wr_addr
);
    a_r1_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |=> (!rsp_valid && !wr_en));

    a_r1_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b00) |=> rsp_valid);

    a_r5_zero_index_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && !req_src_nz) |=> !wr_en);

    a_r6_priv_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b00 && cur_priv < req_addr[9:8]) |=> rsp_illegal);

    a_r7_no_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[11:10] != 2'b11));

    a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_valid && !wr_en && rsp_rdata == '0));

    a_r9_write_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rsp_valid);
endmodule

bind csr_access_unit csr_access_checker #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;
    localparam int XLEN = 32;
    localparam int NREG = 6;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            req_valid = 0;
    logic [1:0]      req_op = 0;
    logic [XLEN-1:0] req_src = 0;
    logic            req_src_nz = 0;
    logic [11:0]     req_addr = 0;
    logic [1:0]      cur_priv = 0;
    logic [11:0]     bank_addr;
    logic [XLEN-1:0] bank_rdata;
    logic            bank_hit;
    logic            rsp_valid, rsp_illegal, wr_en;
    logic [XLEN-1:0] rsp_rdata, wr_data;
    logic [11:0]     wr_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Bank model: four writable, two read-only registers
    logic [11:0]     map_addr [NREG] = '{12'h040, 12'h140, 12'h240, 12'h340, 12'hC01, 12'hF11};
    logic [XLEN-1:0] bank     [NREG];

    always_comb begin
        bank_hit   = 1'b0;
        bank_rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (map_addr[i] == bank_addr) begin
                bank_hit   = 1'b1;
                bank_rdata = bank[i];
            end
    end

    always @(posedge clk)
        if (wr_en)
            for (int i = 0; i < NREG; i++)
                if (map_addr[i] == wr_addr) bank[i] <= wr_data;

    csr_access_unit #(.XLEN(XLEN)) i_csr_access_unit (.*);

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lookup(input logic [11:0] a);
        for (int i = 0; i < NREG; i++) if (map_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic bit want_write(input logic [1:0] op, input logic nz);
        return op == 2'b01 || (op[1] && nz);
    endfunction

    function automatic logic [XLEN-1:0] merge(input logic [1:0] op, input logic [XLEN-1:0] o,
                                              input logic [XLEN-1:0] s);
        if (op == 2'b01) return s;
        if (op == 2'b10) return o | s;
        return o & ~s;
    endfunction

    task automatic access(input logic [1:0] op, input logic [11:0] a, input logic [XLEN-1:0] s,
                          input logic nz, input logic [1:0] pv);
        int              idx = lookup(a);
        logic [XLEN-1:0] old = (idx >= 0) ? bank[idx] : '0;
        bit wr  = want_write(op, nz);
        bit pf  = pv < a[9:8];
        bit rf  = wr && a[11:10] == 2'b11;
        bit uf  = idx < 0;
        bit ill = pf || rf || uf;
        string itag = pf ? "R6" : rf ? "R7" : uf ? "R8" : "R6/R7/R8 legal";
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_src = s; req_src_nz = nz; cur_priv = pv;
        @(negedge clk);
        req_valid = 0;
        if (op == 2'b00) begin
            check(!rsp_valid && !wr_en, "R1 nop", {30'd0, rsp_valid, wr_en}, 0);
        end else begin
            check(rsp_valid, "R1 valid", rsp_valid, 1);
            check(rsp_illegal == ill, itag, rsp_illegal, ill);
            if (ill) begin
                check(rsp_rdata == 0 && !wr_en, "R9 illegal data/write", rsp_rdata, 0);
            end else begin
                check(rsp_rdata == old, "R2 old value", rsp_rdata, old);
                if (!wr) check(!wr_en, "R5 zero index write", wr_en, 0);
                else begin
                    check(wr_en && wr_addr == a, op == 2'b01 ? "R3 write strobe" : "R4 write strobe",
                          {20'd0, wr_addr}, {20'd0, a});
                    check(wr_data == merge(op, old, s), op == 2'b01 ? "R3 data" : "R4 data",
                          wr_data, merge(op, old, s));
                end
            end
        end
        @(negedge clk);
        check(!rsp_valid, "R1 single-cycle", rsp_valid, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        bank = '{32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 32'h4444_0000,
                 32'hC0C0_C0C0, 32'hF00D_F00D};
        #1;
        // R10: reset state
        check(!rsp_valid && !rsp_illegal && !wr_en, "R10 in reset", {29'd0, rsp_valid, rsp_illegal, wr_en}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(!rsp_valid && !rsp_illegal && !wr_en, "R10 after reset", {29'd0, rsp_valid, rsp_illegal, wr_en}, 0);

        // R3 swap, source flag ignored
        access(2'b01, 12'h340, 32'hDEAD_BEEF, 1'b0, 2'd3);
        // R4 set / clear
        access(2'b10, 12'h040, 32'h0000_00F0, 1'b1, 2'd0);
        access(2'b11, 12'h040, 32'h1000_0030, 1'b1, 2'd0);
        // R5 zero index on read-only register: legal, no write
        access(2'b10, 12'hC01, 32'hFFFF_FFFF, 1'b0, 2'd0);
        access(2'b11, 12'hF11, 32'hFFFF_FFFF, 1'b0, 2'd3);
        // R7 read-only writes
        access(2'b10, 12'hC01, 32'h1, 1'b1, 2'd3);
        access(2'b01, 12'hF11, 32'h0, 1'b0, 2'd3);
        // R6 privilege boundaries
        access(2'b01, 12'h140, 32'h55, 1'b1, 2'd1);
        access(2'b01, 12'h140, 32'h66, 1'b1, 2'd0);
        access(2'b01, 12'h340, 32'h77, 1'b1, 2'd2);
        access(2'b10, 12'h240, 32'h08, 1'b1, 2'd2);
        // R8 unmapped
        access(2'b01, 12'h341, 32'h1, 1'b1, 2'd3);
        // R1 nop
        access(2'b00, 12'h040, 32'hFFFF_FFFF, 1'b1, 2'd3);

        for (int n = 0; n < 400; n++) begin
            int pick = $urandom_range(0, NREG);
            logic [11:0] a = (pick == NREG) ? 12'(16'h0300 | $urandom_range(0, 255) | 16'h0002) : map_addr[pick];
            access(2'($urandom_range(0, 3)), a, $urandom, 1'($urandom_range(0, 1)),
                   2'($urandom_range(0, 3)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule